// File: doc/BRIEF.md
# Nested Interrupt Acknowledge Controller

This block decides when a small processor core takes an interrupt. It holds edge-triggered requests from a set of maskable sources and one non-maskable software-break source. Each maskable source has a 2-bit programmable level, where 0 is the most urgent and 3 the least. Decisions are made only when the core signals an instruction boundary.

On acknowledge, the block gives the core four things: a one-cycle acknowledge pulse, the vector address to load, a write that clears the global enable flag, and a two-step save command (status word first, program counter next). An internal stack records each accepted context with its level, its type (maskable or break) and the enable flag value at entry. This stack allows nesting and lets each return restore the flag.

The core supplies the current enable flag and two return strobes, one for each context type. Instruction decode, memory stacking and the flag register stay in the core.

Top module: `nest_irq_ctrl`

## Requirements
- R1: With the enable flag set and nothing in service, a pending maskable source is acknowledged on a boundary. `ack_o` rises in the cycle after the boundary. `vec_o` is 0x0004 + 2 × source index and `ack_src_o` is the index.
- R2: Every acknowledge drives `ie_wr_o`=1 with `ie_val_o`=0 in the same cycle as `ack_o`.
- R3: While the flag is set, a request whose level is numerically less than or equal to the in-service level is acknowledged as a nested interrupt. A request with a numerically greater level is held pending until the stack allows it. An empty stack accepts level 3.
- R4: A maskable request that arrives or waits while the flag is clear is not acknowledged and not lost. It is acknowledged once the flag is set again.
- R5: When several eligible sources are pending at one boundary, the lowest level value wins. Among equal levels, the lowest source index wins.
- R6: A software break (rising edge on `brk_i`) is acknowledged on a boundary regardless of the flag and of levels, and before any maskable request. It gives `ack_brk_o`=1, `vec_o`=0x007E and `ack_src_o`=0. Its stack entry keeps the level already in service (3 if none).
- R7: `push_psw_o` pulses together with `ack_o`, and `push_pc_o` pulses in the following cycle.
- R8: `reti_i` pops only a maskable top entry and `retb_i` pops only a break top entry. A pop drives `ie_wr_o`=1 with `ie_val_o` equal to the flag value sampled at that entry's acknowledge. A mismatched or empty-stack return has no effect.
- R9: No acknowledge occurs in a cycle carrying a return strobe. After a successful pop, the next boundary is consumed by one main-program instruction and yields no acknowledge; acknowledges resume from the boundary after it.
- R10: At most one acknowledge per boundary. The taken source's pending bit clears with the acknowledge. A later rising edge on that source sets it pending again.
- R11: The in-service stack holds 4 entries. When it is full, no acknowledge is issued and requests remain pending.
- R12: After reset, all outputs are 0, the stack is empty and nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 8 | Maskable request lines, rising edge sets pending |
| prio_i | input | 16 | 2-bit level per source, source i at bits [2i+1:2i] |
| brk_i | input | 1 | Software-break request, rising edge sets pending |
| ie_i | input | 1 | Current global enable flag |
| boundary_i | input | 1 | Instruction-boundary strobe |
| reti_i | input | 1 | Return from maskable interrupt |
| retb_i | input | 1 | Return from software break |
| ack_o | output | 1 | Acknowledge pulse |
| ack_brk_o | output | 1 | Acknowledge is a software break |
| ack_src_o | output | 3 | Acknowledged maskable source index |
| vec_o | output | 16 | Vector word address |
| ie_wr_o | output | 1 | Write the enable flag |
| ie_val_o | output | 1 | Value to write to the enable flag |
| push_psw_o | output | 1 | Save status word now |
| push_pc_o | output | 1 | Save program counter now |

## Verification
The hardest situation to reach is a full nest in which the stack holds a break entry sandwiched among maskable entries, while lower-urgency requests are waiting. Under those conditions a return of the wrong type must be ignored, and the one-instruction gap after a valid pop must be honoured.

Directed sequences build that state deliberately:
- they fill the stack with level-0 sources,
- they insert a break while the flag is clear,
- they issue mismatched returns.

A long random phase then mixes request edges, enable writes, boundaries and both return strobes at rates that keep the stack cycling between empty and full. A bench reference model tracks pending bits, the stack and the post-return gap.

// File: rtl/nic_pkg.sv
package nic_pkg;
  localparam int unsigned LVL_W = 2;
  typedef logic [LVL_W-1:0] lvl_t;
  localparam lvl_t LVL_LOWEST = '1;

  typedef struct packed {
    logic is_brk;
    lvl_t lvl;
    logic saved_ie;
  } nic_ctx_t;
endpackage

// File: rtl/nic_pending.sv
module nic_pending #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] req_q, pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= '0;
      pend_q <= '0;
    end else begin
      req_q  <= req_i;
      pend_q <= (pend_q & ~clr_i) | (req_i & ~req_q);
    end
  end

  assign pend_o = pend_q;

  // only a held request may be taken
  assert_clr_pending_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i & ~pend_q) == '0) else $error("clear of idle pending bit");
endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter import nic_pkg::*; #(
  parameter int unsigned N     = 8,
  localparam int unsigned ID_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]       pend_i,
  input  logic [N*LVL_W-1:0] prio_i,
  input  lvl_t               cur_lvl_i,
  output logic               valid_o,
  output logic [ID_W-1:0]    id_o,
  output lvl_t               lvl_o
);
  lvl_t lvl_a [N];

  for (genvar g = 0; g < N; g++) begin : g_lvl
    assign lvl_a[g] = prio_i[g*LVL_W +: LVL_W];
  end

  // strict less-than keeps the lowest index on equal levels
  always_comb begin
    valid_o = 1'b0;
    id_o    = '0;
    lvl_o   = LVL_LOWEST;
    for (int i = 0; i < N; i++) begin
      if (pend_i[i] && lvl_a[i] <= cur_lvl_i && (!valid_o || lvl_a[i] < lvl_o)) begin
        valid_o = 1'b1;
        id_o    = ID_W'(i);
        lvl_o   = lvl_a[i];
      end
    end
  end
endmodule

// File: rtl/nic_level_stack.sv
module nic_level_stack import nic_pkg::*; #(
  parameter int unsigned DEPTH = 4
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     push_i,
  input  logic     pop_i,
  input  nic_ctx_t push_ctx_i,
  output nic_ctx_t top_o,
  output logic     empty_o,
  output logic     full_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [CNT_W-1:0] cnt_q;
  nic_ctx_t         ent_q [DEPTH];
  logic [IDX_W-1:0] top_idx, wr_idx;

  assign top_idx = IDX_W'(cnt_q - 1'b1);
  assign wr_idx  = IDX_W'(cnt_q);
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign top_o   = empty_o ? '0 : ent_q[top_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
    end else if (push_i) begin
      ent_q[wr_idx] <= push_ctx_i;
      cnt_q         <= cnt_q + 1'b1;
    end else if (pop_i) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assert_no_overflow_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o) else $error("push into full stack");
  assert_no_underflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o) else $error("pop from empty stack");
  assert_push_pop_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_i && pop_i)) else $error("push and pop together");
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl import nic_pkg::*; #(
  parameter int unsigned N_SRC    = 8,
  parameter int unsigned DEPTH    = 4,
  parameter logic [15:0] VEC_BASE = 16'h0004,
  parameter logic [15:0] BRK_VEC  = 16'h007E,
  localparam int unsigned SRC_W   = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_SRC-1:0]       req_i,
  input  logic [N_SRC*LVL_W-1:0] prio_i,
  input  logic                   brk_i,
  input  logic                   ie_i,
  input  logic                   boundary_i,
  input  logic                   reti_i,
  input  logic                   retb_i,
  output logic                   ack_o,
  output logic                   ack_brk_o,
  output logic [SRC_W-1:0]       ack_src_o,
  output logic [15:0]            vec_o,
  output logic                   ie_wr_o,
  output logic                   ie_val_o,
  output logic                   push_psw_o,
  output logic                   push_pc_o
);
  logic [N_SRC-1:0] pend, clr;
  logic             brk_pend;
  logic             arb_valid;
  logic [SRC_W-1:0] arb_id;
  lvl_t             arb_lvl, cur_lvl;
  nic_ctx_t         top, push_ctx;
  logic             empty, full;
  logic             pop_irq, pop_brk, pop;
  logic             decide, take_brk, take_irq, take;
  logic             wait_q;
  logic [15:0]      irq_vec;

  logic             ack_q, brk_q, ie_wr_q, ie_val_q, pc_q;
  logic [SRC_W-1:0] src_q;
  logic [15:0]      vec_q;

  nic_pending #(.N(N_SRC)) u_pend (
    .clk_i (clk_i), .rst_ni (rst_ni), .req_i (req_i), .clr_i (clr), .pend_o (pend)
  );

  nic_pending #(.N(1)) u_brk_pend (
    .clk_i (clk_i), .rst_ni (rst_ni), .req_i (brk_i), .clr_i (take_brk), .pend_o (brk_pend)
  );

  nic_arbiter #(.N(N_SRC)) u_arb (
    .pend_i (pend), .prio_i (prio_i), .cur_lvl_i (cur_lvl),
    .valid_o (arb_valid), .id_o (arb_id), .lvl_o (arb_lvl)
  );

  nic_level_stack #(.DEPTH(DEPTH)) u_stack (
    .clk_i (clk_i), .rst_ni (rst_ni), .push_i (take), .pop_i (pop),
    .push_ctx_i (push_ctx), .top_o (top), .empty_o (empty), .full_o (full)
  );

  assign cur_lvl = empty ? LVL_LOWEST : top.lvl;
  assign pop_irq = reti_i & ~empty & ~top.is_brk;
  assign pop_brk = retb_i & ~empty &  top.is_brk;
  assign pop     = pop_irq | pop_brk;

  // return cycles and the first boundary after a pop never acknowledge
  assign decide   = boundary_i & ~wait_q & ~reti_i & ~retb_i & ~full;
  assign take_brk = decide & brk_pend;
  assign take_irq = decide & ~brk_pend & ie_i & arb_valid;
  assign take     = take_brk | take_irq;
  assign clr      = take_irq ? (N_SRC'(1) << arb_id) : '0;
  assign irq_vec  = VEC_BASE + (16'(arb_id) << 1);

  always_comb begin
    push_ctx.is_brk   = take_brk;
    push_ctx.lvl      = take_brk ? cur_lvl : arb_lvl;
    push_ctx.saved_ie = ie_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_q   <= 1'b0;
      ack_q    <= 1'b0;
      brk_q    <= 1'b0;
      src_q    <= '0;
      vec_q    <= '0;
      ie_wr_q  <= 1'b0;
      ie_val_q <= 1'b0;
      pc_q     <= 1'b0;
    end else begin
      if (pop)             wait_q <= 1'b1;
      else if (boundary_i) wait_q <= 1'b0;
      ack_q    <= take;
      brk_q    <= take_brk;
      src_q    <= take_irq ? arb_id : '0;
      vec_q    <= take_brk ? BRK_VEC : (take_irq ? irq_vec : '0);
      ie_wr_q  <= take | pop;
      ie_val_q <= pop & top.saved_ie;
      pc_q     <= ack_q;
    end
  end

  assign ack_o      = ack_q;
  assign ack_brk_o  = brk_q;
  assign ack_src_o  = src_q;
  assign vec_o      = vec_q;
  assign ie_wr_o    = ie_wr_q;
  assign ie_val_o   = ie_val_q;
  assign push_psw_o = ack_q;
  assign push_pc_o  = pc_q;

  assert_ack_on_boundary_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> $past(boundary_i)) else $error("ack without boundary");
  assert_ack_clears_ie_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (ie_wr_o && !ie_val_o)) else $error("ack left flag set");
  assert_arb_eligible_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arb_valid |-> (pend[arb_id] && arb_lvl <= cur_lvl)) else $error("ineligible pick");
  assert_masked_needs_ie_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && !ack_brk_o) |-> $past(ie_i)) else $error("masked ack with flag clear");
  assert_pc_after_psw_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_psw_o |=> push_pc_o) else $error("pc push missing");
  assert_gap_after_return_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ie_wr_o && !ack_o) |=> !ack_o) else $error("ack right after return");
endmodule

// File: tb/nest_irq_ctrl_bench.sv
module nest_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  req = '0;
  logic [15:0] prio = '1;
  logic        brk = 1'b0, ie = 1'b0, bnd = 1'b0, rti = 1'b0, rtb = 1'b0;
  logic        ack, ack_brk, ie_wr, ie_val, push_psw, push_pc;
  logic [2:0]  ack_src;
  logic [15:0] vec;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // reference model state
  logic [7:0] m_pend = '0, m_req_prev = '0;
  logic       m_brkp = 1'b0, m_brk_prev = 1'b0, m_wait = 1'b0, m_ie = 1'b0, m_prev_ack = 1'b0;
  int         m_cnt = 0;
  logic       m_sb [4];
  logic [1:0] m_sl [4];
  logic       m_si [4];

  always #10 clk = ~clk;

  nest_irq_ctrl u_nest_irq_ctrl (
    .clk_i (clk), .rst_ni (rst_n), .req_i (req), .prio_i (prio), .brk_i (brk),
    .ie_i (ie), .boundary_i (bnd), .reti_i (rti), .retb_i (rtb),
    .ack_o (ack), .ack_brk_o (ack_brk), .ack_src_o (ack_src), .vec_o (vec),
    .ie_wr_o (ie_wr), .ie_val_o (ie_val), .push_psw_o (push_psw), .push_pc_o (push_pc)
  );

  function automatic logic [24:0] pack(logic a, logic b, logic [2:0] s, logic [15:0] v,
                                       logic w, logic wv, logic p0, logic p1);
    return {a, b, s, v, w, wv, p0, p1};
  endfunction

  task automatic step(input string tag, input logic [7:0] r, input logic b, input logic bd,
                      input logic ri, input logic rb, input logic ei);
    logic [1:0] cur, bl, pl;
    logic [2:0] bi;
    logic f, dec, e_brk, e_irq, pop, sv;
    logic [15:0] ev;
    logic [24:0] exp_v, act_v;
    if (ei) m_ie = 1'b1;
    req = r; brk = b; bnd = bd; rti = ri; rtb = rb; ie = m_ie;
    pop = 1'b0; sv = 1'b0; cur = 2'd3;
    if (m_cnt > 0) begin
      pop = (ri && !m_sb[m_cnt-1]) || (rb && m_sb[m_cnt-1]);
      sv  = m_si[m_cnt-1];
      cur = m_sl[m_cnt-1];
    end
    dec = bd && !m_wait && !ri && !rb && (m_cnt < 4);
    f = 1'b0; bl = 2'd3; bi = '0;
    for (int i = 0; i < 8; i++) begin
      pl = prio[2*i +: 2];
      if (m_pend[i] && pl <= cur && (!f || pl < bl)) begin
        f = 1'b1; bl = pl; bi = 3'(i);
      end
    end
    e_brk = dec && m_brkp;
    e_irq = dec && !m_brkp && m_ie && f;
    ev = e_brk ? 16'h007E : (e_irq ? 16'h0004 + 16'(bi) * 16'd2 : 16'h0000);
    exp_v = pack(e_brk | e_irq, e_brk, e_irq ? bi : 3'd0, ev, e_brk | e_irq | pop,
                 pop & sv, e_brk | e_irq, m_prev_ack);
    @(negedge clk);
    req = '0; brk = 1'b0; bnd = 1'b0; rti = 1'b0; rtb = 1'b0;
    act_v = pack(ack, ack_brk, ack_src, vec, ie_wr, ie_val, push_psw, push_pc);
    checks++;
    if (act_v !== exp_v) begin
      fails++;
      $display("FAIL %s: {ack,brk,src,vec,iewr,ieval,psw,pc} actual=%h expected=%h", tag, act_v, exp_v);
    end
    if (e_irq) m_pend[bi] = 1'b0;
    m_pend = m_pend | (r & ~m_req_prev);
    m_req_prev = r;
    m_brkp = (m_brkp && !e_brk) || (b && !m_brk_prev);
    m_brk_prev = b;
    if (pop) m_wait = 1'b1;
    else if (bd) m_wait = 1'b0;
    if (e_brk || e_irq) begin
      m_sb[m_cnt] = e_brk;
      m_sl[m_cnt] = e_brk ? cur : bl;
      m_si[m_cnt] = m_ie;
      m_cnt++;
      m_ie = 1'b0;
    end else if (pop) begin
      m_cnt--;
      m_ie = sv;
    end
    m_prev_ack = e_brk || e_irq;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if ({ack, ack_brk, ack_src, vec, ie_wr, ie_val, push_psw, push_pc} !== '0) begin
      fails++;
      $display("FAIL R12: outputs actual=%h expected=0",
               {ack, ack_brk, ack_src, vec, ie_wr, ie_val, push_psw, push_pc});
    end
    step("R12", 8'h00, 0, 1, 0, 0, 0);
    // R1/R2: basic ack, R7 push order
    step("R1", 8'h04, 0, 0, 0, 0, 1);
    step("R1/R2", 8'h00, 0, 1, 0, 0, 0);
    step("R7", 8'h00, 0, 0, 0, 0, 0);
    // R4: flag clear holds request; R3 equal level nests
    step("R4", 8'h20, 0, 0, 0, 0, 0);
    step("R4", 8'h00, 0, 1, 0, 0, 0);
    step("R3", 8'h00, 0, 0, 0, 0, 1);
    step("R3", 8'h00, 0, 1, 0, 0, 0);
    // R9: gap after return
    step("R9", 8'h02, 0, 0, 0, 0, 0);
    step("R8", 8'h00, 0, 0, 1, 0, 0);
    step("R9", 8'h00, 0, 1, 0, 0, 0);
    step("R9", 8'h00, 0, 1, 0, 0, 0);
    // R8: mismatched return ignored
    step("R8", 8'h00, 0, 0, 0, 1, 0);
    step("R8", 8'h00, 0, 0, 0, 0, 0);
    // R6: break with flag clear
    step("R6", 8'h00, 1, 0, 0, 0, 0);
    step("R6", 8'h00, 0, 1, 0, 0, 0);
    step("R7", 8'h00, 0, 0, 0, 0, 0);
    step("R8", 8'h00, 0, 0, 1, 0, 0);
    step("R8", 8'h00, 0, 0, 0, 1, 0);
    step("R8", 8'h00, 0, 0, 1, 0, 0);
    step("R8", 8'h00, 0, 0, 1, 0, 0);
    // R3: less urgent request held
    prio = 16'h0342;
    step("R9", 8'h00, 0, 1, 0, 0, 0);
    step("R3", 8'h01, 0, 0, 0, 0, 1);
    step("R3", 8'h00, 0, 1, 0, 0, 0);
    step("R3", 8'h10, 0, 0, 0, 0, 1);
    step("R3", 8'h00, 0, 1, 0, 0, 0);
    step("R8", 8'h00, 0, 0, 1, 0, 0);
    step("R9", 8'h00, 0, 1, 0, 0, 0);
    step("R3", 8'h00, 0, 1, 0, 0, 0);
    step("R8", 8'h00, 0, 0, 1, 0, 0);
    step("R9", 8'h00, 0, 1, 0, 0, 1);
    // R5: tie break, R10 one per boundary and re-pend
    prio = 16'h5FFE;
    step("R5", 8'hC1, 0, 0, 0, 0, 0);
    step("R5", 8'h00, 0, 1, 0, 0, 0);
    step("R10", 8'h00, 0, 1, 0, 0, 1);
    step("R10", 8'h40, 0, 0, 0, 0, 1);
    step("R10", 8'h00, 0, 1, 0, 0, 0);
    // R11: fill stack to capacity
    prio = 16'h0000;
    step("R11", 8'hFF, 0, 0, 0, 0, 1);
    for (int k = 0; k < 6; k++) step("R11", 8'h00, 0, 1, 0, 0, 1);
    step("R11", 8'h00, 1, 0, 0, 0, 0);
    step("R11", 8'h00, 0, 1, 0, 0, 0);
    for (int k = 0; k < 6; k++) begin
      step("R8", 8'h00, 0, 0, 1, 0, 0);
      step("R9", 8'h00, 0, 1, 0, 0, 1);
      step("R11", 8'h00, 0, 1, 0, 0, 1);
    end
    // constrained random mix
    for (int n = 0; n < 6000; n++) begin
      logic [7:0] rr;
      if (n % 250 == 0) prio = 16'($urandom);
      rr = ($urandom % 4 == 0) ? 8'(1 << ($urandom % 8)) : 8'h00;
      step("R3", rr, ($urandom % 25) == 0, ($urandom % 3) == 0,
           ($urandom % 7) == 0, ($urandom % 12) == 0, ($urandom % 5) == 0);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule